// File: doc/BRIEF.md
# Parallel Port Extended-Mode Negotiator

This block is the host side of the handshake that takes a parallel-port link out of compatibility mode and into an extended transfer mode, and later brings it back. A requester pulses `neg_req_i` with an 8-bit request byte (0x00 asks for nibble mode, 0x30 for the run-length-encoded extended-capability mode). The block puts that byte on the data lines and steps the four host control lines through the event sequence. It watches the five peripheral status lines and reports one result: accepted, rejected, timed out or fault. A pulse on `term_req_i` runs the termination handshake that returns the link to compatibility mode.

All waits are counted in pulses of `tick_i`, a slow pacing strobe from elsewhere on the chip, so the time limits do not depend on the clock frequency. Each wait for the peripheral checks the status condition before it looks at the tick. If the condition is met in the same cycle as the last allowed tick, the handshake still proceeds. The block moves no data once a mode is entered. It only tracks whether an extended mode is currently active.

Result codes on `result_o`: 0 = accepted, 1 = rejected, 2 = timeout, 3 = fault. All line ports carry electrical levels (1 = high).

Top module: `pport_mode_neg`

## Requirements
- R1: A negotiation request made while the select line (`line_sel_o`) is high starts nothing. In the next cycle it completes with result 3 and leaves every line unchanged.
- R2: A negotiation request made with the select line low first drives the request byte on `data_o` and leaves the control lines at select low, feed high, strobe high, init high. After one tick it drives select high and feed low, and strobe and init stay high. `data_o` does not change while the block is busy.
- R3: The block then waits for perror, online and fault all high with ack low. If this condition has not been seen by the 6th tick, the request completes with result 2. A response seen on the cycle of the 6th tick counts as seen.
- R4: Once the response is seen, strobe goes low and stays low until the next tick. Strobe and feed then both return high.
- R5: The block then waits for ack high. If ack is still low at the 7th tick, the request completes with result 3.
- R6: When ack goes high, request byte 0x00 completes with result 0 whatever the level of online. Any other byte completes with result 0 if online is high in that cycle and with result 1 if it is low. `ext_mode_o` rises only on result 0.
- R7: A termination request drives select low and keeps feed, strobe and init high. The block then waits for busy and fault high with ack low. If this is not seen by the 7th tick, the request completes with result 3.
- R8: Once that condition is seen, feed goes low and the block waits for ack high. When ack goes high, feed returns high and the request completes with result 0. If ack is not high by the 6th tick, feed returns high and the request completes with result 3.
- R9: `ext_mode_o` clears in the first cycle of any termination attempt, whether the termination later succeeds or fails.
- R10: Requests that arrive while `busy_o` is high are ignored. When both requests arrive together while the block is idle, termination is taken.
- R11: `done_o` is a one-cycle pulse that comes with a valid `result_o`. `busy_o` stays high from the cycle after a request is taken until the cycle in which `done_o` is high, and it is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Pacing strobe; one pulse is one timeout unit |
| neg_req_i | input | 1 | Start a negotiation |
| term_req_i | input | 1 | Start a termination |
| req_byte_i | input | 8 | Request byte, sampled with `neg_req_i` |
| data_o | output | 8 | Data lines to the peripheral |
| line_sel_o | output | 1 | Host select line level |
| line_feed_o | output | 1 | Host feed line level |
| line_stb_o | output | 1 | Host strobe line level |
| line_init_o | output | 1 | Host init line level |
| line_ack_i | input | 1 | Peripheral ack line level |
| line_busy_i | input | 1 | Peripheral busy line level |
| line_perr_i | input | 1 | Peripheral paper-error line level |
| line_online_i | input | 1 | Peripheral online/select line level |
| line_fault_i | input | 1 | Peripheral fault line level |
| busy_o | output | 1 | A handshake is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | Result code, valid with `done_o` |
| ext_mode_o | output | 1 | An extended mode is active |

## Verification
The bench drives the tick by hand, so it can land the peripheral response exactly on the last allowed tick and can hold it back until one tick past that point. A design with an off-by-one timer would time out early on the first case or accept late on the second. It negotiates nibble mode with online low and the extended mode with online low and high. A design that consulted online for byte 0x00 would reject the nibble request. It also times out a termination and checks that the tracked mode is already cleared, and it makes both requests in the same cycle and makes requests during a busy handshake. A design with the wrong priority or without the busy guard would drive the request byte or show a second result.

// File: rtl/pmn_pkg.sv
package pmn_pkg;

    typedef enum logic [1:0] {
        RES_ACCEPT  = 2'd0,
        RES_REJECT  = 2'd1,
        RES_TIMEOUT = 2'd2,
        RES_FAULT   = 2'd3
    } result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_N_SETUP,
        ST_N_RESP,
        ST_N_STROBE,
        ST_N_LATCH,
        ST_T_RESP,
        ST_T_ACK
    } state_e;

    typedef enum logic [1:0] {
        CHK_NEG_RESP,
        CHK_ACK_HIGH,
        CHK_TERM_RESP
    } check_e;

    typedef struct packed {
        state_e     st;
        logic [7:0] data;
        logic       sel;
        logic       feed;
        logic       stb;
        logic       init;
        logic       ext;
        logic       done;
        result_e    res;
    } ctrl_s;

endpackage

// File: rtl/pmn_tick_timer.sv
module pmn_tick_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic          last_o
);
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW:0]   nxt;

    assign nxt    = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
    // The tick that brings the count up to the limit is the last one.
    assign last_o = tick_i && (nxt == {1'b0, limit_i});

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i && !last_o) begin
            cnt_d = nxt[CW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pmn_status_match.sv
module pmn_status_match
    import pmn_pkg::*;
(
    input  check_e chk_i,
    input  logic   ack_i,
    input  logic   busy_i,
    input  logic   perr_i,
    input  logic   online_i,
    input  logic   fault_i,
    output logic   ok_o
);
    always_comb begin
        unique case (chk_i)
            CHK_NEG_RESP:  ok_o = perr_i && online_i && fault_i && !ack_i;
            CHK_TERM_RESP: ok_o = busy_i && fault_i && !ack_i;
            default:       ok_o = ack_i;
        endcase
    end
endmodule

// File: rtl/pport_mode_neg.sv
module pport_mode_neg
    import pmn_pkg::*;
#(
    parameter int SETUP_TICKS  = 1,
    parameter int RESP_TICKS   = 6,
    parameter int LATCH_TICKS  = 7,
    parameter int STROBE_TICKS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       neg_req_i,
    input  logic       term_req_i,
    input  logic [7:0] req_byte_i,
    output logic [7:0] data_o,
    output logic       line_sel_o,
    output logic       line_feed_o,
    output logic       line_stb_o,
    output logic       line_init_o,
    input  logic       line_ack_i,
    input  logic       line_busy_i,
    input  logic       line_perr_i,
    input  logic       line_online_i,
    input  logic       line_fault_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] result_o,
    output logic       ext_mode_o
);
    localparam int MAX_A = (SETUP_TICKS > STROBE_TICKS) ? SETUP_TICKS : STROBE_TICKS;
    localparam int MAX_B = (RESP_TICKS > LATCH_TICKS) ? RESP_TICKS : LATCH_TICKS;
    localparam int MAXT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAXT + 1);

    ctrl_s         q, n;
    check_e        chk;
    logic [CW-1:0] lim;
    logic          last_tick, cond_ok, tmr_clear;

    // Limit and status condition for the phase held in q.st.
    always_comb begin
        chk = CHK_ACK_HIGH;
        lim = CW'(1);
        unique case (q.st)
            ST_N_SETUP:  lim = CW'(SETUP_TICKS);
            ST_N_RESP:   begin lim = CW'(RESP_TICKS);   chk = CHK_NEG_RESP;  end
            ST_N_STROBE: lim = CW'(STROBE_TICKS);
            ST_N_LATCH:  lim = CW'(LATCH_TICKS);
            ST_T_RESP:   begin lim = CW'(LATCH_TICKS);  chk = CHK_TERM_RESP; end
            ST_T_ACK:    lim = CW'(RESP_TICKS);
            default:     lim = CW'(1);
        endcase
    end

    pmn_status_match u_match (
        .chk_i    (chk),
        .ack_i    (line_ack_i),
        .busy_i   (line_busy_i),
        .perr_i   (line_perr_i),
        .online_i (line_online_i),
        .fault_i  (line_fault_i),
        .ok_o     (cond_ok)
    );

    pmn_tick_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (tmr_clear),
        .tick_i  (tick_i),
        .limit_i (lim),
        .last_o  (last_tick)
    );

    // Each phase starts with a fresh count.
    assign tmr_clear = (n.st != q.st);

    always_comb begin
        n      = q;
        n.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (term_req_i) begin
                    n.st   = ST_T_RESP;
                    n.sel  = 1'b0;
                    n.feed = 1'b1;
                    n.stb  = 1'b1;
                    n.init = 1'b1;
                    n.ext  = 1'b0;
                end else if (neg_req_i) begin
                    if (q.sel) begin
                        n.done = 1'b1;
                        n.res  = RES_FAULT;
                    end else begin
                        n.st   = ST_N_SETUP;
                        n.data = req_byte_i;
                    end
                end
            end
            ST_N_SETUP: begin
                if (last_tick) begin
                    n.st   = ST_N_RESP;
                    n.sel  = 1'b1;
                    n.feed = 1'b0;
                end
            end
            ST_N_RESP: begin
                if (cond_ok) begin
                    n.st  = ST_N_STROBE;
                    n.stb = 1'b0;
                end else if (last_tick) begin
                    n.st   = ST_IDLE;
                    n.done = 1'b1;
                    n.res  = RES_TIMEOUT;
                end
            end
            ST_N_STROBE: begin
                if (last_tick) begin
                    n.st   = ST_N_LATCH;
                    n.stb  = 1'b1;
                    n.feed = 1'b1;
                end
            end
            ST_N_LATCH: begin
                if (cond_ok) begin
                    n.st   = ST_IDLE;
                    n.done = 1'b1;
                    if (q.data == 8'h00 || line_online_i) begin
                        n.res = RES_ACCEPT;
                        n.ext = 1'b1;
                    end else begin
                        n.res = RES_REJECT;
                    end
                end else if (last_tick) begin
                    n.st   = ST_IDLE;
                    n.done = 1'b1;
                    n.res  = RES_FAULT;
                end
            end
            ST_T_RESP: begin
                if (cond_ok) begin
                    n.st   = ST_T_ACK;
                    n.feed = 1'b0;
                end else if (last_tick) begin
                    n.st   = ST_IDLE;
                    n.done = 1'b1;
                    n.res  = RES_FAULT;
                end
            end
            ST_T_ACK: begin
                if (cond_ok || last_tick) begin
                    n.st   = ST_IDLE;
                    n.feed = 1'b1;
                    n.done = 1'b1;
                    n.res  = cond_ok ? RES_ACCEPT : RES_FAULT;
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.data <= 8'h00;
            q.sel  <= 1'b0;
            q.feed <= 1'b1;
            q.stb  <= 1'b1;
            q.init <= 1'b1;
            q.ext  <= 1'b0;
            q.done <= 1'b0;
            q.res  <= RES_ACCEPT;
        end else begin
            q <= n;
        end
    end

    assign data_o      = q.data;
    assign line_sel_o  = q.sel;
    assign line_feed_o = q.feed;
    assign line_stb_o  = q.stb;
    assign line_init_o = q.init;
    assign busy_o      = (q.st != ST_IDLE);
    assign done_o      = q.done;
    assign result_o    = q.res;
    assign ext_mode_o  = q.ext;
endmodule

// File: rtl/pmn_checker.sv
module pmn_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       neg_req_i,
    input logic       term_req_i,
    input logic [7:0] data_o,
    input logic       line_sel_o,
    input logic       line_feed_o,
    input logic       line_stb_o,
    input logic       busy_o,
    input logic       done_o,
    input logic [1:0] result_o,
    input logic       ext_mode_o
);
    assert_blocked_neg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_req_i && !term_req_i && !busy_o && line_sel_o) |=> (done_o && result_o == 2'd3));

    assert_data_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(data_o));

    assert_strobe_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !line_stb_o |-> (line_sel_o && !line_feed_o));

    assert_ext_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_mode_o) |-> (done_o && result_o == 2'd0));

    assert_term_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_sel_o) |-> (line_feed_o && line_stb_o));

    assert_mode_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_sel_o) |-> !ext_mode_o);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

bind pport_mode_neg pmn_checker u_pmn_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .neg_req_i   (neg_req_i),
    .term_req_i  (term_req_i),
    .data_o      (data_o),
    .line_sel_o  (line_sel_o),
    .line_feed_o (line_feed_o),
    .line_stb_o  (line_stb_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .result_o    (result_o),
    .ext_mode_o  (ext_mode_o)
);

// File: tb/pport_mode_neg_bench.sv
`timescale 1ns/1ps
module pport_mode_neg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       neg_req_i = 1'b0;
    logic       term_req_i = 1'b0;
    logic [7:0] req_byte_i = 8'h00;
    logic [7:0] data_o;
    logic       line_sel_o, line_feed_o, line_stb_o, line_init_o;
    logic       line_ack_i = 1'b1;
    logic       line_busy_i = 1'b0;
    logic       line_perr_i = 1'b0;
    logic       line_online_i = 1'b0;
    logic       line_fault_i = 1'b1;
    logic       busy_o, done_o, ext_mode_o;
    logic [1:0] result_o;

    int checks = 0;
    int failures = 0;
    int n_done = 0;
    logic [1:0] last_res = 2'd0;

    localparam logic [1:0] ACC = 2'd0, REJ = 2'd1, TMO = 2'd2, FLT = 2'd3;

    always #2 clk = ~clk;

    pport_mode_neg u_pport_mode_neg (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .neg_req_i(neg_req_i), .term_req_i(term_req_i), .req_byte_i(req_byte_i),
        .data_o(data_o), .line_sel_o(line_sel_o), .line_feed_o(line_feed_o),
        .line_stb_o(line_stb_o), .line_init_o(line_init_o),
        .line_ack_i(line_ack_i), .line_busy_i(line_busy_i), .line_perr_i(line_perr_i),
        .line_online_i(line_online_i), .line_fault_i(line_fault_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .ext_mode_o(ext_mode_o)
    );

    always @(posedge clk) begin
        #1;
        if (done_o) begin
            n_done   = n_done + 1;
            last_res = result_o;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic tick1();
        tick_i = 1'b1;
        cyc();
        tick_i = 1'b0;
    endtask

    task automatic set_st(input logic ack, input logic bsy, input logic perr,
                          input logic onl, input logic flt);
        line_ack_i = ack; line_busy_i = bsy; line_perr_i = perr;
        line_online_i = onl; line_fault_i = flt;
    endtask

    task automatic lines(input string req, input int s, input int f, input int st, input int in);
        chk(req, "select", int'(line_sel_o), s);
        chk(req, "feed", int'(line_feed_o), f);
        chk(req, "strobe", int'(line_stb_o), st);
        chk(req, "init", int'(line_init_o), in);
    endtask

    // Start a negotiation and bring it to the ack wait.
    task automatic neg_to_latch(input logic [7:0] b);
        set_st(1, 0, 0, 0, 1);
        req_byte_i = b;
        neg_req_i = 1'b1;
        cyc();
        neg_req_i = 1'b0;
        chk("R2", "data on bus", int'(data_o), int'(b));
        lines("R2", 0, 1, 1, 1);
        chk("R11", "busy after request", int'(busy_o), 1);
        tick1();
        lines("R2", 1, 0, 1, 1);
        set_st(0, 0, 1, 1, 1);
        cyc();
        chk("R4", "strobe low", int'(line_stb_o), 0);
        cyc();
        chk("R4", "strobe held until tick", int'(line_stb_o), 0);
        tick1();
        lines("R4", 1, 1, 1, 1);
    endtask

    task automatic term_ok();
        int d0;
        d0 = n_done;
        term_req_i = 1'b1;
        cyc();
        term_req_i = 1'b0;
        set_st(0, 1, 0, 1, 1);
        cyc();
        set_st(1, 0, 0, 1, 1);
        cyc();
        chk("R8", "recovery termination result", int'(last_res), int'(ACC));
        chk("R8", "recovery done count", n_done, d0 + 1);
    endtask

    task automatic t_reset();
        lines("R2", 0, 1, 1, 1);
        chk("R11", "reset busy", int'(busy_o), 0);
        chk("R11", "reset done", int'(done_o), 0);
        chk("R9", "reset ext", int'(ext_mode_o), 0);
    endtask

    task automatic t_nibble();
        int d0;
        neg_to_latch(8'h00);
        d0 = n_done;
        set_st(1, 0, 1, 0, 1);
        cyc();
        chk("R6", "nibble done", n_done, d0 + 1);
        chk("R6", "nibble accepted with online low", int'(last_res), int'(ACC));
        chk("R6", "ext after nibble", int'(ext_mode_o), 1);
        chk("R11", "busy low with done", int'(busy_o), 0);
        cyc();
        chk("R11", "done one cycle", int'(done_o), 0);
    endtask

    task automatic t_blocked();
        int d0;
        d0 = n_done;
        req_byte_i = 8'h30;
        neg_req_i = 1'b1;
        cyc();
        neg_req_i = 1'b0;
        chk("R1", "blocked done", n_done, d0 + 1);
        chk("R1", "blocked result", int'(last_res), int'(FLT));
        chk("R1", "blocked busy", int'(busy_o), 0);
        chk("R1", "blocked data untouched", int'(data_o), 0);
        chk("R1", "select unchanged", int'(line_sel_o), 1);
    endtask

    task automatic t_term_success();
        int d0;
        d0 = n_done;
        term_req_i = 1'b1;
        cyc();
        term_req_i = 1'b0;
        lines("R7", 0, 1, 1, 1);
        chk("R9", "ext cleared on attempt", int'(ext_mode_o), 0);
        set_st(0, 1, 0, 1, 1);
        cyc();
        chk("R8", "feed low", int'(line_feed_o), 0);
        set_st(1, 1, 0, 1, 1);
        cyc();
        chk("R8", "feed raised", int'(line_feed_o), 1);
        chk("R8", "term result", int'(last_res), int'(ACC));
        chk("R8", "term done", n_done, d0 + 1);
    endtask

    task automatic t_ecp_accept_term_timeout();
        int d0;
        neg_to_latch(8'h30);
        set_st(1, 0, 1, 1, 1);
        cyc();
        chk("R6", "ecp accepted with online high", int'(last_res), int'(ACC));
        chk("R6", "ext set", int'(ext_mode_o), 1);
        d0 = n_done;
        term_req_i = 1'b1;
        cyc();
        term_req_i = 1'b0;
        chk("R9", "ext cleared at start", int'(ext_mode_o), 0);
        for (int i = 0; i < 6; i++) tick1();
        chk("R7", "no result before 7th tick", n_done, d0);
        chk("R7", "still busy", int'(busy_o), 1);
        tick1();
        chk("R7", "term timeout result", int'(last_res), int'(FLT));
        chk("R7", "term timeout done", n_done, d0 + 1);
        chk("R9", "ext stays clear after failed term", int'(ext_mode_o), 0);
        lines("R7", 0, 1, 1, 1);
    endtask

    task automatic t_reject_then_ack_timeout();
        int d0;
        neg_to_latch(8'h30);
        set_st(1, 0, 1, 0, 1);
        cyc();
        chk("R6", "ecp rejected with online low", int'(last_res), int'(REJ));
        chk("R6", "ext after reject", int'(ext_mode_o), 0);
        term_req_i = 1'b1;
        cyc();
        term_req_i = 1'b0;
        set_st(0, 1, 0, 1, 1);
        cyc();
        chk("R8", "feed low before ack timeout", int'(line_feed_o), 0);
        d0 = n_done;
        for (int i = 0; i < 5; i++) tick1();
        chk("R8", "no result before 6th tick", n_done, d0);
        tick1();
        chk("R8", "ack timeout result", int'(last_res), int'(FLT));
        chk("R8", "feed raised after timeout", int'(line_feed_o), 1);
    endtask

    task automatic t_resp_timeout();
        int d0;
        set_st(1, 0, 0, 0, 1);
        req_byte_i = 8'h30;
        neg_req_i = 1'b1;
        cyc();
        neg_req_i = 1'b0;
        tick1();
        d0 = n_done;
        for (int i = 0; i < 5; i++) tick1();
        chk("R3", "no timeout before 6th tick", n_done, d0);
        tick1();
        chk("R3", "timeout result", int'(last_res), int'(TMO));
        chk("R3", "timeout done", n_done, d0 + 1);
        term_ok();
    endtask

    task automatic t_resp_last_tick_then_latch_fault();
        int d0;
        set_st(1, 0, 0, 0, 1);
        req_byte_i = 8'h10;
        neg_req_i = 1'b1;
        cyc();
        neg_req_i = 1'b0;
        tick1();
        d0 = n_done;
        for (int i = 0; i < 5; i++) tick1();
        set_st(0, 0, 1, 1, 1);
        tick1();
        chk("R3", "response on 6th tick proceeds", int'(line_stb_o), 0);
        chk("R3", "no timeout", n_done, d0);
        tick1();
        for (int i = 0; i < 6; i++) tick1();
        chk("R5", "no fault before 7th tick", n_done, d0);
        tick1();
        chk("R5", "ack wait fault", int'(last_res), int'(FLT));
        chk("R5", "ack wait done", n_done, d0 + 1);
        term_ok();
    endtask

    task automatic t_priority_and_busy();
        int d0;
        d0 = n_done;
        set_st(1, 0, 0, 0, 1);
        req_byte_i = 8'hA5;
        neg_req_i = 1'b1;
        term_req_i = 1'b1;
        cyc();
        neg_req_i = 1'b0;
        term_req_i = 1'b0;
        chk("R10", "termination wins, byte not driven", int'(data_o == 8'hA5), 0);
        chk("R10", "busy in termination", int'(busy_o), 1);
        neg_req_i = 1'b1;
        cyc();
        neg_req_i = 1'b0;
        chk("R10", "request while busy gives no result", n_done, d0);
        set_st(0, 1, 0, 1, 1);
        cyc();
        term_req_i = 1'b1;
        cyc();
        term_req_i = 1'b0;
        set_st(1, 0, 0, 1, 1);
        cyc();
        chk("R10", "single result", n_done, d0 + 1);
        cyc();
        chk("R10", "idle afterwards", int'(busy_o), 0);
        chk("R10", "byte never driven", int'(data_o == 8'hA5), 0);
        lines("R10", 0, 1, 1, 1);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_nibble();
        t_blocked();
        t_term_success();
        t_ecp_accept_term_timeout();
        t_reject_then_ack_timeout();
        t_resp_timeout();
        t_resp_last_tick_then_latch_fault();
        t_priority_and_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule